// File: doc/BRIEF.md
# Host Port Read Strobe Sequencer

This block is a bus master that performs 16-bit read accesses to the host port of a signal processor over an expansion bus. Each access has four timed phases in a fixed order: address, data setup, strobe and recovery. Each phase lasts its programmed count plus one clock. Address and chip select are driven together when the access starts. The data strobe goes low only in the strobe phase. The read data is sampled on the last clock of the strobe.

The target can stretch an access with its wait line, but only in the address phase and the strobe phase. The local requester raises a request with an address and four phase counts. It receives a one-cycle acknowledge, with the captured word, once recovery has finished. Counts below each phase's floor are raised to that floor. The address and the counts are captured when the access starts, so changes on those inputs during the access have no effect on it.

Top module: `rd_strobe_seq`

## Requirements
- R1: While `rst_ni` is low, and asynchronously when it falls, the block is idle with `bus_cs_no`=1, `bus_ds_no`=1 and `ack_o`=0.
- R2: A clock edge in idle with `req_i`=1 starts an access. On that edge `bus_addr_o` takes `addr_i` and `bus_cs_no` falls. `addr_i` and the four counts are captured on that edge, and later changes to them do not affect the running access.
- R3: With no wait, the phases last, in order, address count+1, setup count+1, strobe count+1 and recovery count+1 clocks.
- R4: Effective counts have the floors address 2, setup 2, strobe 1 and recovery 0. A lower programmed value runs as the floor.
- R5: `bus_cs_no` is low through the address, setup and strobe phases and high in recovery and idle. `bus_ds_no` is low only in the strobe phase, which is never the first clock of an access. `bus_addr_o` is unchanged from the start of an access through its recovery.
- R6: Each clock edge in the address or strobe phase that sees `bus_wait_i`=1 lengthens that phase by one clock. A phase can end only on an edge that sees `bus_wait_i`=0.
- R7: `bus_wait_i` has no effect in the setup phase, in the recovery phase or in idle.
- R8: `rdata_o` takes the value of `bus_data_i` sampled on the clock edge that ends the strobe phase.
- R9: `ack_o` is high for exactly one clock, the clock after the last recovery clock, with `rdata_o` valid. If `req_i` is still high in that clock, the next access starts on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Expansion bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, sampled in idle |
| addr_i | input | AW | Read address |
| t_addr_i | input | PW | Address phase count |
| t_setup_i | input | PW | Data setup phase count |
| t_strobe_i | input | PW | Strobe phase count |
| t_recov_i | input | PW | Recovery phase count |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| bus_addr_o | output | AW | Bus address |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_ds_no | output | 1 | Data strobe, active low |
| bus_data_i | input | DW | Bus read data |
| bus_wait_i | input | 1 | Target wait, active high |

## Verification
The assertions assume that `bus_wait_i` and `bus_data_i` are synchronous to `clk_i` and hold steady around each rising edge. They also assume the requester changes its inputs only between edges. The bench drives every input on the falling edge. It places each wait window by counting the clocks of the current access as seen on the chip select and the strobe. Windows aimed at the address phase start no later than its last unstretched clock. Windows aimed at the setup phase end before the strobe begins, so the expected phase lengths follow directly from the counts and the window lengths.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_RECOV  = 3'd4
  } phase_e;

  // index of each phase count in the parameter arrays
  localparam int unsigned F_ADDR   = 0;
  localparam int unsigned F_SETUP  = 1;
  localparam int unsigned F_STROBE = 2;
  localparam int unsigned F_RECOV  = 3;
  localparam int unsigned NUM_F    = 4;
endpackage

// File: rtl/rsq_param_latch.sv
module rsq_param_latch #(
  parameter int PW         = 4,
  parameter int MIN_ADDR   = 2,
  parameter int MIN_SETUP  = 2,
  parameter int MIN_STROBE = 1,
  parameter int MIN_RECOV  = 0
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              load_i,
  input  logic [PW-1:0]                     t_addr_i,
  input  logic [PW-1:0]                     t_setup_i,
  input  logic [PW-1:0]                     t_strobe_i,
  input  logic [PW-1:0]                     t_recov_i,
  output logic [rsq_pkg::NUM_F-1:0][PW-1:0] clamp_o,
  output logic [rsq_pkg::NUM_F-1:0][PW-1:0] eff_o
);
  import rsq_pkg::*;

  localparam int MINS [NUM_F] = '{MIN_ADDR, MIN_SETUP, MIN_STROBE, MIN_RECOV};

  logic [NUM_F-1:0][PW-1:0] raw;
  assign raw = {t_recov_i, t_strobe_i, t_setup_i, t_addr_i};

  for (genvar g = 0; g < NUM_F; g++) begin : g_field
    localparam logic [PW-1:0] LO = PW'(MINS[g]);

    assign clamp_o[g] = (raw[g] < LO) ? LO : raw[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     eff_o[g] <= LO;
      else if (load_i) eff_o[g] <= clamp_o[g];
    end
  end
endmodule

// File: rtl/rsq_phase_ctr.sv
module rsq_phase_ctr #(
  parameter int PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] load_val_i,
  input  logic          hold_i,
  output logic          done_o
);
  logic [PW-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (!hold_i && !done_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   wait_i,
  input  logic                   done_i,
  output rsq_pkg::phase_e        phase_o,
  output logic                   start_o,
  output logic                   load_o,
  output logic [1:0]             load_sel_o,
  output logic                   hold_o,
  output logic                   capture_o,
  output logic                   finish_o
);
  import rsq_pkg::*;

  phase_e phase_q, phase_d;

  assign phase_o = phase_q;

  always_comb begin
    phase_d    = phase_q;
    start_o    = 1'b0;
    load_o     = 1'b0;
    load_sel_o = 2'(F_ADDR);
    hold_o     = 1'b0;
    capture_o  = 1'b0;
    finish_o   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          phase_d = PH_ADDR;
          start_o = 1'b1;
          load_o  = 1'b1;
        end
      end
      PH_ADDR: begin
        hold_o = wait_i;
        if (!wait_i && done_i) begin
          phase_d    = PH_SETUP;
          load_o     = 1'b1;
          load_sel_o = 2'(F_SETUP);
        end
      end
      PH_SETUP: begin
        if (done_i) begin
          phase_d    = PH_STROBE;
          load_o     = 1'b1;
          load_sel_o = 2'(F_STROBE);
        end
      end
      PH_STROBE: begin
        hold_o = wait_i;
        if (!wait_i && done_i) begin
          phase_d    = PH_RECOV;
          load_o     = 1'b1;
          load_sel_o = 2'(F_RECOV);
          capture_o  = 1'b1;
        end
      end
      PH_RECOV: begin
        if (done_i) begin
          phase_d  = PH_IDLE;
          finish_o = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end
endmodule

// File: rtl/rd_strobe_seq.sv
module rd_strobe_seq #(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int PW         = 4,
  parameter int MIN_ADDR   = 2,
  parameter int MIN_SETUP  = 2,
  parameter int MIN_STROBE = 1,
  parameter int MIN_RECOV  = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [PW-1:0] t_addr_i,
  input  logic [PW-1:0] t_setup_i,
  input  logic [PW-1:0] t_strobe_i,
  input  logic [PW-1:0] t_recov_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_cs_no,
  output logic          bus_ds_no,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_wait_i
);
  import rsq_pkg::*;

  phase_e                   phase;
  logic                     start, load, hold, capture, finish, done;
  logic [1:0]               load_sel;
  logic [NUM_F-1:0][PW-1:0] clamp, eff;
  logic [PW-1:0]            load_val;
  logic [AW-1:0]            addr_q;
  logic [DW-1:0]            rdata_q;
  logic                     ack_q;

  rsq_param_latch #(
    .PW        (PW),
    .MIN_ADDR  (MIN_ADDR),
    .MIN_SETUP (MIN_SETUP),
    .MIN_STROBE(MIN_STROBE),
    .MIN_RECOV (MIN_RECOV)
  ) u_param (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start),
    .t_addr_i  (t_addr_i),
    .t_setup_i (t_setup_i),
    .t_strobe_i(t_strobe_i),
    .t_recov_i (t_recov_i),
    .clamp_o   (clamp),
    .eff_o     (eff)
  );

  rsq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .wait_i    (bus_wait_i),
    .done_i    (done),
    .phase_o   (phase),
    .start_o   (start),
    .load_o    (load),
    .load_sel_o(load_sel),
    .hold_o    (hold),
    .capture_o (capture),
    .finish_o  (finish)
  );

  // first phase loads straight from the clamped inputs, later ones from the latch
  assign load_val = start ? clamp[load_sel] : eff[load_sel];

  rsq_phase_ctr #(.PW(PW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .hold_i    (hold),
    .done_o    (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      if (start)   addr_q  <= addr_i;
      if (capture) rdata_q <= bus_data_i;
      ack_q <= finish;
    end
  end

  assign bus_addr_o = addr_q;
  assign bus_cs_no  = !(phase == PH_ADDR || phase == PH_SETUP || phase == PH_STROBE);
  assign bus_ds_no  = (phase != PH_STROBE);
  assign rdata_o    = rdata_q;
  assign ack_o      = ack_q;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_cs_no,
  input logic          bus_ds_no,
  input logic          bus_wait_i
);
  p_ds_inside_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_ds_no |-> !bus_cs_no);

  p_no_strobe_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_cs_no) |-> bus_ds_no);

  p_addr_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && !$past(bus_cs_no)) |-> $stable(bus_addr_o));

  p_strobe_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ds_no) |=> !bus_ds_no);

  p_strobe_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ds_no && bus_wait_i) |=> !bus_ds_no);

  p_ack_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  p_ack_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (bus_cs_no && bus_ds_no));
endmodule

bind rd_strobe_seq rsq_checker #(.AW(AW)) u_rsq_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ack_o     (ack_o),
  .bus_addr_o(bus_addr_o),
  .bus_cs_no (bus_cs_no),
  .bus_ds_no (bus_ds_no),
  .bus_wait_i(bus_wait_i)
);

// File: tb/rd_strobe_seq_bench.sv
`timescale 1ns/1ps
module rd_strobe_seq_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int PW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [PW-1:0] t_addr_i = '0, t_setup_i = '0, t_strobe_i = '0, t_recov_i = '0;
  logic          ack_o;
  logic [DW-1:0] rdata_o;
  logic [AW-1:0] bus_addr_o;
  logic          bus_cs_no, bus_ds_no;
  logic [DW-1:0] bus_data_i = '0;
  logic          bus_wait_i = 1'b0;

  rd_strobe_seq #(.AW(AW), .DW(DW), .PW(PW)) u_rd_strobe_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .t_addr_i(t_addr_i), .t_setup_i(t_setup_i), .t_strobe_i(t_strobe_i),
    .t_recov_i(t_recov_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .bus_addr_o(bus_addr_o), .bus_cs_no(bus_cs_no), .bus_ds_no(bus_ds_no),
    .bus_data_i(bus_data_i), .bus_wait_i(bus_wait_i)
  );

  always #10 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;

  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endfunction

  // expectation for the next access (copied by the monitor when it starts)
  int n_ea, n_es, n_eb, n_er, n_wa_s, n_wa_l, n_ws_s, n_ws_l, n_wb_s, n_wb_l;
  bit n_wr;
  logic [AW-1:0] n_addr;
  int c_ea, c_es, c_eb, c_er, c_wa_s, c_wa_l, c_ws_s, c_ws_l, c_wb_s, c_wb_l;
  bit c_wr;
  logic [AW-1:0] c_addr;
  bit idle_w = 1'b0;

  bit in_acc = 1'b0, seen_strb, bad;
  int pre_i, strb_j, rec_k;
  logic [15:0] lfsr = 16'hace1;
  logic [DW-1:0] exp_data;
  int acks = 0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      in_acc     = 1'b0;
      bus_wait_i = 1'b0;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!bus_cs_no) begin
        if (!in_acc) begin
          in_acc = 1'b1; seen_strb = 1'b0; bad = 1'b0;
          pre_i = 0; strb_j = 0; rec_k = 0;
          c_ea = n_ea; c_es = n_es; c_eb = n_eb; c_er = n_er;
          c_wa_s = n_wa_s; c_wa_l = n_wa_l; c_ws_s = n_ws_s; c_ws_l = n_ws_l;
          c_wb_s = n_wb_s; c_wb_l = n_wb_l; c_wr = n_wr; c_addr = n_addr;
        end
        if (bus_addr_o !== c_addr) bad = 1'b1;
        if (bus_ds_no) begin
          if (seen_strb) bad = 1'b1;
          pre_i++;
        end else begin
          seen_strb = 1'b1;
          strb_j++;
          exp_data = lfsr;
        end
      end else if (in_acc) begin
        if (!bus_ds_no) bad = 1'b1;
        if (ack_o) begin
          acks++;
          // R3 R4 R6 R7: address + setup length including address stretch
          chk(pre_i == c_ea + 1 + c_es + 1 + c_wa_l, "R3 R6 pre-strobe clocks", pre_i,
              c_ea + c_es + 2 + c_wa_l);
          chk(strb_j == c_eb + 1 + c_wb_l, "R3 R6 strobe clocks", strb_j, c_eb + 1 + c_wb_l);
          chk(rec_k == c_er + 1, "R3 R7 recovery clocks", rec_k, c_er + 1);
          chk(rdata_o === exp_data, "R8 R9 captured data", int'(rdata_o), int'(exp_data));
          chk(!bad, "R5 cs/ds/address order", int'(bad), 0);
          in_acc = 1'b0;
        end else begin
          rec_k++;
          if (bus_addr_o !== c_addr) bad = 1'b1;
        end
      end else if (ack_o || !bus_ds_no) begin
        chk(1'b0, "R9 stray ack or strobe", int'(ack_o), 0);
      end
      bus_data_i = lfsr;
      if (in_acc && !bus_cs_no) begin
        if (bus_ds_no)
          bus_wait_i = (pre_i >= c_wa_s && pre_i < c_wa_s + c_wa_l) ||
                       (pre_i >= c_ws_s && pre_i < c_ws_s + c_ws_l);
        else
          bus_wait_i = (strb_j >= c_wb_s && strb_j < c_wb_s + c_wb_l);
      end else if (in_acc) begin
        bus_wait_i = c_wr;
      end else begin
        bus_wait_i = idle_w;
      end
    end
  end

  function automatic int floor_to(int v, int lo);
    return (v < lo) ? lo : v;
  endfunction

  // call at a negedge with the block idle
  task automatic set_next(int ta, int ts, int tb, int tr, int wa_s, int wa_l,
                          int ws_l, int wb_s, int wb_l, bit wr, logic [AW-1:0] a);
    n_ea = floor_to(ta, 2); n_es = floor_to(ts, 2);
    n_eb = floor_to(tb, 1); n_er = floor_to(tr, 0);
    n_wa_s = wa_s; n_wa_l = wa_l;
    n_ws_s = n_ea + 1 + wa_l + 1; n_ws_l = ws_l;
    n_wb_s = wb_s; n_wb_l = wb_l; n_wr = wr; n_addr = a;
    addr_i = a;
    t_addr_i = PW'(ta); t_setup_i = PW'(ts); t_strobe_i = PW'(tb); t_recov_i = PW'(tr);
  endtask

  task automatic run(int ta, int ts, int tb, int tr, int wa_s, int wa_l, int ws_l,
                     int wb_s, int wb_l, bit wr, bit scramble);
    logic [AW-1:0] a;
    a = AW'(lfsr ^ 16'h5a3c);
    set_next(ta, ts, tb, tr, wa_s, wa_l, ws_l, wb_s, wb_l, wr, a);
    req_i = 1'b1;
    @(negedge clk_i);
    chk(bus_cs_no === 1'b0 && bus_addr_o === a, "R2 start address", int'(bus_addr_o), int'(a));
    @(negedge clk_i);
    req_i = 1'b0;
    if (scramble) begin
      // R2: inputs changed mid-access must be ignored
      addr_i = ~a; t_addr_i = '1; t_setup_i = '0; t_strobe_i = '1; t_recov_i = '1;
    end
    while (!ack_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", acks, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(bus_cs_no === 1'b1 && bus_ds_no === 1'b1 && ack_o === 1'b0, "R1 reset idle",
        int'({bus_cs_no, bus_ds_no, ack_o}), 6);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 R4: sweep counts around and below the floors
    for (int ta = 0; ta < 5; ta++)
      for (int ts = 0; ts < 5; ts++)
        for (int tb = 0; tb < 4; tb++)
          for (int tr = 0; tr < 3; tr++)
            run(ta, ts, tb, tr, 0, 0, 0, 0, 0, 1'b0, 1'((ta + ts + tb + tr) % 2));

    // R6 address stretch: early, first clock, last unstretched clock
    run(2, 2, 1, 0, 2, 3, 0, 0, 0, 1'b0, 1'b1);
    run(3, 2, 1, 1, 1, 1, 0, 0, 0, 1'b0, 1'b0);
    run(2, 3, 2, 0, 3, 2, 0, 0, 0, 1'b0, 1'b0);
    // R7 wait across the whole setup phase is ignored
    run(2, 3, 1, 0, 0, 0, 4, 0, 0, 1'b0, 1'b0);
    // R6 strobe stretch
    run(2, 2, 1, 0, 0, 0, 0, 1, 2, 1'b0, 1'b0);
    run(4, 2, 3, 2, 0, 0, 0, 4, 4, 1'b0, 1'b1);
    // R7 wait during recovery and idle ignored
    idle_w = 1'b1;
    run(2, 2, 1, 3, 0, 0, 0, 0, 0, 1'b1, 1'b0);
    run(0, 0, 0, 0, 0, 0, 2, 0, 0, 1'b1, 1'b0);
    idle_w = 1'b0;
    // all windows together
    run(3, 4, 2, 2, 2, 2, 5, 2, 3, 1'b1, 1'b1);

    // R9 back-to-back: req held through ack
    set_next(2, 2, 1, 1, 0, 0, 0, 0, 0, 1'b0, 16'h1234);
    req_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    set_next(3, 2, 2, 0, 0, 0, 0, 0, 0, 1'b0, 16'hbeef);
    while (!ack_o) @(negedge clk_i);
    @(negedge clk_i);
    chk(bus_cs_no === 1'b0 && bus_addr_o === 16'hbeef, "R9 back-to-back start",
        int'(bus_addr_o), 16'hbeef);
    req_i = 1'b0;
    while (!ack_o) @(negedge clk_i);
    @(negedge clk_i);

    // R1 asynchronous reset during the strobe
    set_next(2, 2, 3, 0, 0, 0, 0, 0, 0, 1'b0, 16'h0f0f);
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    while (bus_ds_no) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(bus_cs_no === 1'b1 && bus_ds_no === 1'b1 && ack_o === 1'b0, "R1 async reset",
        int'({bus_cs_no, bus_ds_no, ack_o}), 6);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(bus_cs_no === 1'b1 && ack_o === 1'b0, "R1 stays idle after reset",
        int'({bus_cs_no, ack_o}), 2);
    run(2, 2, 1, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule